// File: doc/BRIEF.md
# Zero-Crossing Triac Firing Pulse Generator

This block drives a triac gate with a fixed-width firing pulse at every mains zero crossing. Two mains sync inputs report the crossings: the first marks one crossing with its rising edge, and the second marks the next crossing with its falling edge. A gating window input decides which half-cycles are allowed to fire. The pulse width is set in prescaled clock ticks. A firing count register enables firing when it is nonzero.

The block has one interrupt request. Three event sources feed it: a rising edge of the gating window, a falling edge of the gating window, and the start of each firing pulse. Each source has its own mask bit. All three sources are always generated inside the block, and the mask decides which of them pass to the request. Every asynchronous input goes through a two-flop synchroniser before any edge is detected.

Top module: `triac_zc_pulser`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `fire_out` and `irq` are both low.
- R2: A rising edge on `sync_a` starts a pulse. The pulse is visible on `fire_out` after the third rising clock edge that follows the input change.
- R3: A falling edge on `sync_b` starts a pulse with the same three-edge latency. A rising edge on `sync_b` and a falling edge on `sync_a` start nothing.
- R4: A pulse stays high for exactly `pulse_len * (presc_div + 1)` clock cycles.
- R5: If `pulse_len` is zero or `fire_count` is zero, a zero crossing produces no pulse and no pulse interrupt.
- R6: A zero crossing that arrives while the synchronised `gate_win` is low produces no pulse.
- R7: The `int_mask` bits work as follows. Bit 0 passes rising edges of `gate_win`. Bit 1 passes its falling edges. Bit 2 passes pulse starts. Each passed event gives a one-cycle strobe on `irq`. For a pulse start, the strobe falls in the first cycle that `fire_out` is high. For a gate edge, the strobe appears three clock edges after the input change.
- R8: When `int_mask` is 000, no event produces an `irq` strobe.
- R9: A zero crossing that arrives during a pulse restarts the full pulse width from that crossing. It also raises a new pulse interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_a | input | 1 | First mains sync; its rising edge is a zero crossing |
| sync_b | input | 1 | Second mains sync; its falling edge is a zero crossing |
| gate_win | input | 1 | Firing window; half-cycles fire only while it is high |
| presc_div | input | PRE_W | Prescaler value N; one tick every N+1 clocks |
| pulse_len | input | LEN_W | Pulse width in prescaler ticks |
| fire_count | input | CNT_W | Firing count; zero disables firing |
| int_mask | input | 3 | Interrupt source enables {pulse, gate fall, gate rise} |
| fire_out | output | 1 | Triac firing output |
| irq | output | 1 | One-cycle interrupt strobe |

## Verification
A tick counter or remaining-width count that goes wrong shows at the ports as a pulse of the wrong width. The error appears at the falling edge of `fire_out`, within `pulse_len*(N+1)` cycles of the start. A broken edge detector or synchroniser shows up three cycles after the input change, as a missing pulse, a pulse on the wrong edge, or an `irq` strobe in the wrong cycle. A bad gate or enable qualifier shows at once as a pulse where none was allowed. A wrong restart shows as a pulse that is too short when a second crossing arrives during a pulse.

// File: rtl/triac_zc_pulser.sv
module triac_zc_pulser #(
  parameter int PRE_W = 8,
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_a,
  input  logic             sync_b,
  input  logic             gate_win,
  input  logic [PRE_W-1:0] presc_div,
  input  logic [LEN_W-1:0] pulse_len,
  input  logic [CNT_W-1:0] fire_count,
  input  logic [2:0]       int_mask,
  output logic             fire_out,
  output logic             irq
);

  logic [2:0] a_q, b_q, g_q;
  logic [PRE_W-1:0] tick_cnt;
  logic [LEN_W-1:0] left;
  logic busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      g_q <= '0;
    end else begin
      a_q <= {a_q[1:0], sync_a};
      b_q <= {b_q[1:0], sync_b};
      g_q <= {g_q[1:0], gate_win};
    end

  wire gate_ok  = g_q[1];
  wire a_rise   = a_q[1] & ~a_q[2];
  wire b_fall   = ~b_q[1] & b_q[2];
  wire g_rise   = g_q[1] & ~g_q[2];
  wire g_fall   = ~g_q[1] & g_q[2];
  wire enabled  = (pulse_len != '0) && (fire_count != '0);
  wire start    = (a_rise | b_fall) & gate_ok & enabled;
  wire tick     = (tick_cnt == presc_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
      left     <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
      left     <= pulse_len;
    end else if (busy) begin
      if (tick) begin
        tick_cnt <= '0;
        left     <= left - 1'b1;
        if (left == LEN_W'(1)) busy <= 1'b0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(int_mask & {start, g_fall, g_rise});

  assign fire_out = busy;

  AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> left != '0); // R4
  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_out) |-> ($past(pulse_len) != '0 && $past(fire_count) != '0)); // R5
  AST_FIRE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_out) |-> $past(gate_ok)); // R6
  AST_PULSE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fire_out) && $past(int_mask[2])) |-> irq); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_mask) != 3'b000); // R8

endmodule

// File: tb/triac_zc_pulser_test.sv
module triac_zc_pulser_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_a = 1'b0, sync_b = 1'b0, gate_win = 1'b1;
  logic [7:0]  presc_div = '0;
  logic [15:0] pulse_len = '0;
  logic [7:0]  fire_count = '0;
  logic [2:0]  int_mask = '0;
  logic fire_out, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  triac_zc_pulser uut (.clk(clk), .rst_n(rst_n), .sync_a(sync_a), .sync_b(sync_b),
    .gate_win(gate_win), .presc_div(presc_div), .pulse_len(pulse_len),
    .fire_count(fire_count), .int_mask(int_mask), .fire_out(fire_out), .irq(irq));

  always #4 clk = ~clk;

  // columns: use sync_b, presc, len, fcount, mask, expected width
  localparam int NV = 7;
  localparam int TV [NV][6] = '{
    '{0, 0, 4, 1, 4, 4},
    '{1, 0, 4, 1, 4, 4},
    '{0, 2, 3, 5, 0, 9},
    '{1, 4, 5, 1, 4, 25},
    '{0, 0, 0, 3, 4, 0},
    '{1, 3, 6, 0, 4, 0},
    '{0, 1, 1, 1, 4, 2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_edge(input bit use_b, output int dly, output int wid,
                          output int irqs, output int irq_at_start);
    dly = -1; wid = 0; irqs = 0; irq_at_start = 0;
    if (use_b) begin
      sync_b = 1'b1;
      wait_neg(6);
      sync_b = 1'b0;
    end else sync_a = 1'b1;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (fire_out && dly < 0) begin dly = i; irq_at_start = irq; end
      if (fire_out) wid++;
      if (irq) irqs++;
      if (dly >= 0 && !fire_out) break;
    end
    sync_a = 1'b0;
    wait_neg(6);
  endtask

  initial begin
    int d, w, q, s;
    wait_neg(3);
    check("R1 fire_out in reset", fire_out, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fire_out after reset", fire_out, 0);
    check("R1 irq after reset", irq, 0);
    wait_neg(5);

    for (int k = 0; k < NV; k++) begin
      presc_div = 8'(TV[k][1]);
      pulse_len = 16'(TV[k][2]);
      fire_count = 8'(TV[k][3]);
      int_mask = 3'(TV[k][4]);
      run_edge(TV[k][0] != 0, d, w, q, s);
      check(TV[k][0] != 0 ? "R3 width via sync_b" : "R2 width via sync_a", w, TV[k][5]);
      check("R4 width formula", w, TV[k][2] * (TV[k][1] + 1) * ((TV[k][3] != 0) ? 1 : 0));
      if (TV[k][5] > 0) check(TV[k][0] != 0 ? "R3 latency" : "R2 latency", d, 3);
      check("R5 R7 pulse irq count", q, (TV[k][5] > 0 && TV[k][4][2]) ? 1 : 0);
      if (TV[k][5] > 0 && TV[k][4][2]) check("R7 irq with first high cycle", s, 1);
    end

    // R3: falling sync_a and rising sync_b do nothing
    presc_div = 0; pulse_len = 5; fire_count = 1; int_mask = 3'b100;
    sync_a = 1'b1; wait_neg(8);
    sync_a = 1'b0; sync_b = 1'b1; w = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); w += fire_out; end
    check("R3 no pulse on wrong edges", w, 0);
    sync_b = 1'b0; wait_neg(20);

    // R6: gate low blocks firing
    int_mask = 3'b000; gate_win = 1'b0; wait_neg(6);
    run_edge(0, d, w, q, s);
    check("R6 gate low no pulse", w, 0);
    run_edge(1, d, w, q, s);
    check("R6 gate low no pulse sync_b", w, 0);

    // R7 / R8 gate edge interrupts
    int_mask = 3'b001; gate_win = 1'b1; q = 0; d = -1;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); if (irq) begin q++; if (d < 0) d = i; end end
    check("R7 gate rise irq count", q, 1);
    check("R7 gate rise irq cycle", d, 3);
    gate_win = 1'b0; q = 0;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); q += irq; end
    check("R7 gate fall masked by bit1", q, 0);
    int_mask = 3'b010; gate_win = 1'b1; q = 0;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); q += irq; end
    check("R7 gate rise masked by bit0", q, 0);
    gate_win = 1'b0; q = 0;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); q += irq; end
    check("R7 gate fall irq", q, 1);
    int_mask = 3'b000; gate_win = 1'b1; q = 0;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); q += irq; end
    check("R8 mask zero gate rise", q, 0);
    run_edge(0, d, w, q, s);
    check("R8 mask zero pulse irq", q, 0);
    check("R8 pulse still fires", w, 5);

    // R9: retrigger restarts width
    presc_div = 0; pulse_len = 10; fire_count = 1; int_mask = 3'b100;
    sync_b = 1'b1; wait_neg(6);
    sync_a = 1'b1; w = 0; q = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 5) sync_b = 1'b0;
      w += fire_out; q += irq;
    end
    check("R9 retrigger width", w, 15);
    check("R9 retrigger irq count", q, 2);
    sync_a = 1'b0;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule